// File: doc/BRIEF.md
# Cache Array Window Port

This block lets software reach the tag storage and the line storage of a 4-way set-associative instruction cache and operand cache through plain 32-bit loads and stores. A bus request carries an address, and the block decodes that address into the cache it targets, the array it targets (tag or data), a way, an entry index and, for tag windows, an associative-operation flag. It then performs a single read or write on the selected storage. Normal lookup traffic, refill and write-back to external memory are outside this block.

Requests use a valid/ready handshake. The block accepts at most one request per clock cycle. Each accepted request produces exactly one response, one cycle later. That response carries the read data, an error flag and the decoded associative flag. Illegal requests never modify storage. They return zero data together with a one-cycle error pulse.

Top module: `cache_window_port`

## Requirements
- R1: A request is inside a window when address bits 31:25 equal 7'b1111000. Bit 24 selects the array (0 = tag, 1 = data) and bit 23 selects the cache (0 = instruction, 1 = operand). The four windows hold independent storage.
- R2: Address bits 12:11 give the way (00 = way 0 through 11 = way 3). Bits 10:4 give the entry (128 entries). In data windows, bits 3:2 pick one of the four 32-bit words of the line.
- R3: A tag-window read returns {3'b000, tag[28:10], lru[9:4], 2'b00, dirty[1], valid[0]}. Bits 31:29 always read as zero, whatever was written to them.
- R4: A tag-window write stores tag, dirty and valid for the addressed way and entry. It stores the LRU field once per entry, and that field is shared by all four ways.
- R5: The instruction-cache dirty bit always reads 0, and writes to it are ignored.
- R6: Tag reads return the addressed way regardless of the A bit (address bit 3). rsp_assoc reports that bit for legal tag-window requests and is 0 for every other response.
- R7: A data-window write stores the 32-bit word, and a later read of the same address returns it.
- R8: A request is illegal when req_size is not 2'b10 (longword; 00 = byte, 01 = halfword), when address bits 1:0 are not 00, when req_fetch is 1, or when the address is outside every window. An illegal request gives rsp_err = 1 and rsp_rdata = 0, and it changes no storage.
- R9: req_ready is 0 during reset and 1 from the first clock edge after reset. rsp_valid is 1 in exactly the cycle after each accepted request and 0 in all other cycles.
- R10: While reset is held, rsp_valid, rsp_err and rsp_assoc are 0.
- R11: A legal write responds with rsp_err = 0 and rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 longword |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Illegal request |
| rsp_assoc | output | 1 | Decoded A bit of a legal tag-window request |
| rsp_rdata | output | 32 | Load data, zero for stores and errors |

## Verification
The assertions check the handshake timing on every cycle: every accepted request gets exactly one response one cycle later, and no response appears without a request. They also check that size and fetch violations always raise the error flag, and that an error response never carries data. Only the bench scenarios can show the storage behaviour. This covers the packing of the tag word, the sharing of LRU across ways, the dropped instruction-cache dirty bit, the separation between windows and ways, and the absence of side effects from illegal stores. Those checks depend on the values written earlier.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int WORD_W = 32;
  localparam logic [6:0] WINDOW_HI = 7'b1111000;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_LONG = 2'b10
  } size_e;
  typedef enum logic [1:0] {
    SEL_IC_TAG  = 2'b00,
    SEL_OC_TAG  = 2'b01,
    SEL_IC_DATA = 2'b10,
    SEL_OC_DATA = 2'b11
  } sel_e;
endpackage

// File: rtl/cwp_decode.sv
module cwp_decode
  import cwp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic [WORD_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic                       fetch,
  output logic                       legal,
  output logic                       is_data,
  output logic                       is_oc,
  output logic [$clog2(WAYS)-1:0]    way,
  output logic [$clog2(ENTRIES)-1:0] index,
  output logic [$clog2(LINE_WORDS)-1:0] word,
  output logic                       assoc
);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int IDX_LSB = 2 + WSEL_W;
  localparam int WAY_LSB = IDX_LSB + IDX_W;

  logic in_win;
  logic unused_bits;

  assign in_win  = (addr[31:25] == WINDOW_HI);
  assign legal   = in_win && (size == SZ_LONG) && (addr[1:0] == 2'b00) && !fetch;
  assign is_data = addr[24];
  assign is_oc   = addr[23];
  assign way     = addr[WAY_LSB +: WAY_W];
  assign index   = addr[IDX_LSB +: IDX_W];
  assign word    = addr[2 +: WSEL_W];
  assign assoc   = !addr[24] && addr[IDX_LSB-1];
  assign unused_bits = ^addr[22:WAY_LSB+WAY_W];
endmodule

// File: rtl/cwp_tag_bank.sv
module cwp_tag_bank
  import cwp_pkg::*;
#(
  parameter bit HAS_DIRTY = 1'b1,
  parameter int WAYS      = 4,
  parameter int ENTRIES   = 128,
  parameter int TAG_W     = 19,
  parameter int LRU_W     = 6
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       re,
  input  logic [$clog2(WAYS)-1:0]    way,
  input  logic [$clog2(ENTRIES)-1:0] index,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata
);
  localparam int TAG_LSB = LRU_W + 4;
  localparam int PAD_W   = WORD_W - TAG_W - LRU_W - 4;
  localparam int DEPTH   = WAYS * ENTRIES;
  localparam int ENT_W   = TAG_W + 2;

  // Per-way entry: {tag, dirty, valid}; LRU kept once per index.
  logic [ENT_W-1:0] ent_mem [DEPTH];
  logic [LRU_W-1:0] lru_mem [ENTRIES];
  logic [ENT_W-1:0] ent_q;
  logic [LRU_W-1:0] lru_q;
  logic             dirty_in;
  logic             dirty_rd;
  logic             unused_bits;

  generate
    if (HAS_DIRTY) begin : g_dirty
      assign dirty_in = wdata[1];
      assign dirty_rd = ent_q[1];
    end else begin : g_nodirty
      assign dirty_in = 1'b0;
      assign dirty_rd = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) begin
      ent_mem[{way, index}] <= {wdata[TAG_LSB +: TAG_W], dirty_in, wdata[0]};
      lru_mem[index]        <= wdata[4 +: LRU_W];
    end
    if (re) begin
      ent_q <= ent_mem[{way, index}];
      lru_q <= lru_mem[index];
    end
  end

  assign rdata = {{PAD_W{1'b0}}, ent_q[ENT_W-1:2], lru_q, 2'b00, dirty_rd, ent_q[0]};
  assign unused_bits = ^{wdata[WORD_W-1 -: PAD_W], wdata[3:1], ent_q[1]};
endmodule

// File: rtl/cwp_data_bank.sv
module cwp_data_bank
  import cwp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic                          re,
  input  logic [$clog2(WAYS)-1:0]       way,
  input  logic [$clog2(ENTRIES)-1:0]    index,
  input  logic [$clog2(LINE_WORDS)-1:0] word,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             rdata
);
  localparam int DEPTH = WAYS * ENTRIES * LINE_WORDS;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{way, index, word}] <= wdata;
    if (re) rdata <= mem[{way, index, word}];
  end
endmodule

// File: rtl/cache_window_port.sv
module cache_window_port
  import cwp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 128,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 19,
  parameter int LRU_W      = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic        rsp_assoc,
  output logic [31:0] rsp_rdata
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WSEL_W = $clog2(LINE_WORDS);

  logic              legal, is_data, is_oc, assoc;
  logic [WAY_W-1:0]  way;
  logic [IDX_W-1:0]  index;
  logic [WSEL_W-1:0] word;
  logic              acc, go;
  logic              ready_q, valid_q, err_q, assoc_q, rd_q;
  sel_e              sel_q;
  logic [WORD_W-1:0] bank_rd [4];

  cwp_decode #(.WAYS(WAYS), .ENTRIES(ENTRIES), .LINE_WORDS(LINE_WORDS)) u_dec (
    .addr(req_addr), .size(req_size), .fetch(req_fetch), .legal(legal),
    .is_data(is_data), .is_oc(is_oc), .way(way), .index(index), .word(word),
    .assoc(assoc)
  );

  assign acc = req_valid && ready_q;
  assign go  = acc && legal;

  // Index c: 0 = instruction cache, 1 = operand cache.
  for (genvar c = 0; c < 2; c++) begin : g_cache
    logic hit_tag, hit_data;
    assign hit_tag  = go && !is_data && (is_oc == c[0]);
    assign hit_data = go &&  is_data && (is_oc == c[0]);

    cwp_tag_bank #(
      .HAS_DIRTY(c == 1), .WAYS(WAYS), .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LRU_W(LRU_W)
    ) u_tag (
      .clk(clk), .we(hit_tag && req_write), .re(hit_tag && !req_write),
      .way(way), .index(index), .wdata(req_wdata), .rdata(bank_rd[c])
    );

    cwp_data_bank #(.WAYS(WAYS), .ENTRIES(ENTRIES), .LINE_WORDS(LINE_WORDS)) u_data (
      .clk(clk), .we(hit_data && req_write), .re(hit_data && !req_write),
      .way(way), .index(index), .word(word), .wdata(req_wdata), .rdata(bank_rd[2+c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      assoc_q <= 1'b0;
      rd_q    <= 1'b0;
      sel_q   <= SEL_IC_TAG;
    end else begin
      ready_q <= 1'b1;
      valid_q <= acc;
      err_q   <= acc && !legal;
      assoc_q <= go && assoc;
      rd_q    <= go && !req_write;
      if (go) sel_q <= sel_e'({is_data, is_oc});
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_assoc = assoc_q;
  assign rsp_rdata = rd_q ? bank_rd[sel_q] : '0;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid); // R9
  AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid); // R9
  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    (acc && req_size != SZ_LONG) |=> rsp_err); // R8
  AST_FETCH_ERR: assert property (@(posedge clk) disable iff (rst)
    (acc && req_fetch) |=> rsp_err); // R8
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr[1:0] != 2'b00) |=> rsp_err); // R8
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0 && !rsp_assoc)); // R8
  AST_ASSOC_ON_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_assoc |-> rsp_valid); // R6
endmodule

// File: tb/cache_window_port_tb_top.sv
module cache_window_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {wr, fetch, size[2], addr[32], wdata[32], exp_err, exp_assoc, exp_rdata[32]}
  localparam logic [101:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd2, 32'hF080_1050, 32'hE000_0403, 1'b0, 1'b0, 32'h0000_0000}, // R4 R11 OC tag w2 e5
    {1'b1, 1'b0, 2'd2, 32'hF080_0850, 32'h0ABC_D5F1, 1'b0, 1'b0, 32'h0000_0000}, // R4 OC tag w1 e5
    {1'b0, 1'b0, 2'd2, 32'hF080_1058, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_05F3}, // R3 R4 R6 shared LRU, A=1
    {1'b0, 1'b0, 2'd2, 32'hF080_0850, 32'h0000_0000, 1'b0, 1'b0, 32'h0ABC_D5F1}, // R2 way separation
    {1'b1, 1'b0, 2'd2, 32'hF000_1800, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000}, // R5 IC tag w3 e0
    {1'b0, 1'b0, 2'd2, 32'hF000_1808, 32'h0000_0000, 1'b0, 1'b1, 32'h1FFF_FFF1}, // R3 R5 R6
    {1'b1, 1'b0, 2'd2, 32'hF100_07FC, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0000_0000}, // R7 IC data
    {1'b1, 1'b0, 2'd2, 32'hF180_07FC, 32'h1234_5678, 1'b0, 1'b0, 32'h0000_0000}, // R7 OC data
    {1'b1, 1'b0, 2'd2, 32'hF180_07F8, 32'hCAFE_0001, 1'b0, 1'b0, 32'h0000_0000}, // R2 word 2
    {1'b0, 1'b0, 2'd2, 32'hF100_07FC, 32'h0000_0000, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R1 R6 R7
    {1'b0, 1'b0, 2'd2, 32'hF180_07FC, 32'h0000_0000, 1'b0, 1'b0, 32'h1234_5678}, // R1 R7
    {1'b1, 1'b0, 2'd2, 32'hF180_07FE, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R8 misaligned
    {1'b0, 1'b0, 2'd0, 32'hF180_07FC, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R8 byte size
    {1'b1, 1'b1, 2'd2, 32'hF080_1050, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R8 fetch
    {1'b1, 1'b0, 2'd2, 32'hF200_07FC, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R1 R8 outside
    {1'b0, 1'b0, 2'd2, 32'hF180_07FC, 32'h0000_0000, 1'b0, 1'b0, 32'h1234_5678}  // R8 unchanged
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, rsp_assoc;
  logic [31:0] rsp_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_window_port dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_assoc(rsp_assoc), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic fe, input logic [1:0] sz,
                       input logic [31:0] ad, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_fetch = fe; req_size = sz;
    req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", {31'd0, req_ready}, 32'd0);
    chk("R10 valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R10 err/assoc in reset", {30'd0, rsp_err, rsp_assoc}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ready after reset", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      issue(v[101], v[100], v[99:98], v[97:66], v[65:34]);
      chk($sformatf("R9 vec%0d valid", i), {31'd0, rsp_valid}, 32'd1);
      chk($sformatf("R8 vec%0d err", i), {31'd0, rsp_err}, {31'd0, v[33]});
      chk($sformatf("R6 vec%0d assoc", i), {31'd0, rsp_assoc}, {31'd0, v[32]});
      chk($sformatf("R3 R7 R11 vec%0d data", i), rsp_rdata, v[31:0]);
    end

    // R9: no response in an idle cycle
    @(negedge clk);
    chk("R9 idle no response", {31'd0, rsp_valid}, 32'd0);

    // R8: illegal fetch-store left OC tag w2 e5 intact
    issue(1'b0, 1'b0, 2'd2, 32'hF080_1050, 32'h0);
    chk("R8 tag unchanged", rsp_rdata, 32'h0000_05F3);

    // R4: rewrite LRU through way 3 of entry 5, visible in way 2
    issue(1'b1, 1'b0, 2'd2, 32'hF080_1850, 32'h0000_0020);
    issue(1'b0, 1'b0, 2'd2, 32'hF080_1050, 32'h0);
    chk("R4 LRU shared across ways", rsp_rdata, 32'h0000_0423);

    // R2 R7: word 2 of the same line stays distinct from word 3
    issue(1'b0, 1'b0, 2'd2, 32'hF180_07F8, 32'h0);
    chk("R2 word select", rsp_rdata, 32'hCAFE_0001);

    // R8: halfword store to data window does not write
    issue(1'b1, 1'b0, 2'd1, 32'hF100_07FC, 32'h0BAD_0BAD);
    chk("R8 halfword err", {31'd0, rsp_err}, 32'd1);
    issue(1'b0, 1'b0, 2'd2, 32'hF100_07FC, 32'h0);
    chk("R8 data unchanged", rsp_rdata, 32'hDEAD_BEEF);

    // R9: back-to-back requests each get a response
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_fetch = 1'b0; req_size = 2'd2;
    req_addr = 32'hF180_07FC;
    @(negedge clk);
    chk("R9 b2b first", rsp_rdata, 32'h1234_5678);
    req_addr = 32'hF180_07F8;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 b2b second", rsp_rdata, 32'hCAFE_0001);
    chk("R9 b2b valid", {31'd0, rsp_valid}, 32'd1);

    finish_run();
  end
endmodule